// File: doc/BRIEF.md
# DMA Request Priority and Mask Unit

This unit sits between the peripheral request lines of a DMA controller and its central sequencer. It watches one request line per channel. Each channel can be set to respond to the line's level, or to a rising edge that is latched until the channel has been serviced. Channels whose mask bit is set are left out. The unit then chooses one winner among the remaining channels, using either fixed or rotating priority. It presents a single registered request and the winning channel number to the sequencer.

The sequencer holds `seq_grant` high while it services the presented request. The unit freezes its choice for that whole time and drives the acknowledge line of the served channel, so that the peripheral withdraws its request. When `seq_grant` drops, the service is complete. The unit then clears any latched edge for that channel and records the channel as the most recently served. Arbitration resumes after that. The CPU side programs the mask, the trigger sense and the priority mode through three write strobes, each with its own data.

Top module: `dma_req_arbiter`

## Requirements
- R1: After reset, `req_valid` is 0 and `dack` is all zeros. Every channel is masked, every channel uses level sense, priority is fixed, and the most recently served channel is NUM_CH-1.
- R2: A write strobe loads its data into its configuration register at the clock edge where the strobe is high. Arbitration uses the new value from the following edge onward.
- R3: Bit i of the mask register belongs to channel i, and a 1 masks that channel. A masked channel never becomes the winner, and `req_valid` is 0 when every requesting channel is masked.
- R4: If bit i of the sense register is 0, channel i requests for as long as `dreq[i]` is high. The arbitration result appears after the first clock edge at which the high level is sampled.
- R5: If bit i of the sense register is 1, a rising edge on `dreq[i]` is latched, and even a one-cycle pulse is kept. The request appears after the second edge and stays pending after the line falls, until the service of that channel completes. A line that stays high does not request again.
- R6: When the priority mode bit is 0 (fixed), the lowest-numbered qualified channel wins.
- R7: When the priority mode bit is 1 (rotating), the search starts at the channel after the most recently served one, wrapping from NUM_CH-1 to 0. The served channel therefore ranks lowest.
- R8: At any edge where `seq_grant` is high or a service is in progress, `req_valid` and `req_ch` keep their values.
- R9: A service starts at an edge where `seq_grant` and `req_valid` are both 1. From the next cycle, `dack` is one-hot at bit `req_ch` for as long as `seq_grant` stays high.
- R10: At the first edge where `seq_grant` is low during a service, the service ends. `dack` returns to zero, the latched edge of the served channel is cleared, and the served channel becomes the most recently served. Arbitration resumes at the edge after that.
- R11: If `seq_grant` is high while `req_valid` is 0, no service starts and `dack` stays zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dreq | input | NUM_CH | Peripheral request lines |
| cfg_mask_we | input | 1 | Write strobe for the mask register |
| cfg_mask_d | input | NUM_CH | Mask data, 1 = masked |
| cfg_sense_we | input | 1 | Write strobe for the sense register |
| cfg_sense_d | input | NUM_CH | Sense data, 1 = edge, 0 = level |
| cfg_prio_we | input | 1 | Write strobe for the priority mode |
| cfg_prio_d | input | 1 | Priority mode, 1 = rotating, 0 = fixed |
| seq_grant | input | 1 | Sequencer is servicing the presented request |
| req_valid | output | 1 | A qualified request is presented |
| req_ch | output | CH_W | Winning channel number |
| dack | output | NUM_CH | Per-channel acknowledge |

## Verification
The bench builds the unit with its defaults: four channels and the rotating variant enabled. With that configuration, every request pattern can be swept against every value of the mask. Every pattern can also be swept in fixed mode, and in rotating mode after each channel in turn has been served, so that all sixty-four pointer and pattern pairs are checked against a priority search computed in the bench. The small channel count also makes it practical to walk edge latching, short pulses, the freeze during a grant and a grant with no request through exact cycle counts.

// File: rtl/dma_arb_pkg.sv
package dma_arb_pkg;
   typedef enum logic {
      PRIO_FIXED  = 1'b0,
      PRIO_ROTATE = 1'b1
   } prio_mode_e;

   typedef enum logic {
      SENSE_LEVEL = 1'b0,
      SENSE_EDGE  = 1'b1
   } sense_e;
endpackage

// File: rtl/dma_req_detect.sv
module dma_req_detect #(
   parameter int NUM_CH = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NUM_CH-1:0] dreq,
   input  logic [NUM_CH-1:0] sense,
   input  logic [NUM_CH-1:0] mask,
   input  logic [NUM_CH-1:0] clr,
   output logic [NUM_CH-1:0] req_qual
);
   import dma_arb_pkg::*;

   for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
      logic prev_r;
      logic pend_r;
      logic rise;

      assign rise = dreq[i] & ~prev_r;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            prev_r <= 1'b0;
            pend_r <= 1'b0;
         end else begin
            prev_r <= dreq[i];
            pend_r <= ((pend_r & ~clr[i]) | rise) & (sense[i] == SENSE_EDGE);
         end
      end

      assign req_qual[i] = ~mask[i] & ((sense[i] == SENSE_EDGE) ? pend_r : dreq[i]);

      // R5
      pend_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (pend_r && !clr[i] && sense[i]) |=> (pend_r || !sense[i]));
   end
endmodule

// File: rtl/dma_prio_pick.sv
module dma_prio_pick #(
   parameter int NUM_CH = 4,
   parameter bit ROT_EN = 1'b1,
   localparam int CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
   input  logic [NUM_CH-1:0] req,
   input  logic              rot_mode,
   input  logic [CH_W-1:0]   last_ch,
   output logic              any,
   output logic [CH_W-1:0]   win
);
   assign any = |req;

   if (ROT_EN) begin : g_rot
      always_comb begin
         int  base;
         int  idx;
         logic found;
         base  = rot_mode ? int'(last_ch) + 1 : 0;
         if (base >= NUM_CH) base = base - NUM_CH;
         found = 1'b0;
         win   = '0;
         for (int k = 0; k < NUM_CH; k++) begin
            idx = base + k;
            if (idx >= NUM_CH) idx = idx - NUM_CH;
            if (!found && req[idx]) begin
               found = 1'b1;
               win   = CH_W'(idx);
            end
         end
      end
   end else begin : g_fixed
      logic unused_cfg;
      assign unused_cfg = ^{rot_mode, last_ch};
      always_comb begin
         win = '0;
         for (int k = NUM_CH - 1; k >= 0; k--) begin
            if (req[k]) win = CH_W'(k);
         end
      end
   end
endmodule

// File: rtl/dma_grant_ctrl.sv
module dma_grant_ctrl #(
   parameter int NUM_CH = 4,
   localparam int CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              seq_grant,
   input  logic              req_valid,
   input  logic [CH_W-1:0]   req_ch,
   output logic              hold,
   output logic [NUM_CH-1:0] dack,
   output logic [NUM_CH-1:0] clr,
   output logic [CH_W-1:0]   last_ch
);
   logic            svc_act;
   logic [CH_W-1:0] svc_ch;
   logic [CH_W-1:0] last_q;
   logic            done;
   logic [NUM_CH-1:0] svc_hot;

   assign done    = svc_act & ~seq_grant;
   assign svc_hot = NUM_CH'(1) << svc_ch;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         svc_act <= 1'b0;
         svc_ch  <= '0;
         last_q  <= CH_W'(NUM_CH - 1);
      end else begin
         svc_act <= seq_grant & (svc_act | req_valid);
         if (!svc_act && seq_grant && req_valid) svc_ch <= req_ch;
         if (done) last_q <= svc_ch;
      end
   end

   assign hold    = seq_grant | svc_act;
   assign dack    = svc_act ? svc_hot : '0;
   assign clr     = done ? svc_hot : '0;
   assign last_ch = last_q;

   // R9
   svc_needs_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
      svc_act |-> $past(seq_grant));

   // R11
   no_req_no_svc_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (seq_grant && !svc_act && !req_valid) |=> !svc_act);
endmodule

// File: rtl/dma_req_arbiter.sv
module dma_req_arbiter #(
   parameter int NUM_CH = 4,
   parameter bit ROT_EN = 1'b1,
   localparam int CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NUM_CH-1:0] dreq,
   input  logic              cfg_mask_we,
   input  logic [NUM_CH-1:0] cfg_mask_d,
   input  logic              cfg_sense_we,
   input  logic [NUM_CH-1:0] cfg_sense_d,
   input  logic              cfg_prio_we,
   input  logic              cfg_prio_d,
   input  logic              seq_grant,
   output logic              req_valid,
   output logic [CH_W-1:0]   req_ch,
   output logic [NUM_CH-1:0] dack
);
   import dma_arb_pkg::*;

   if (NUM_CH < 2 || NUM_CH > 32) begin : g_bad_cfg
      $error("dma_req_arbiter: NUM_CH must lie in 2..32");
   end

   logic [NUM_CH-1:0] mask_q;
   logic [NUM_CH-1:0] sense_q;
   prio_mode_e        prio_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mask_q  <= '1;
         sense_q <= '0;
         prio_q  <= PRIO_FIXED;
      end else begin
         if (cfg_mask_we)  mask_q  <= cfg_mask_d;
         if (cfg_sense_we) sense_q <= cfg_sense_d;
         if (cfg_prio_we)  prio_q  <= prio_mode_e'(cfg_prio_d);
      end
   end

   logic [NUM_CH-1:0] qual;
   logic [NUM_CH-1:0] clr;
   logic              hold;
   logic [CH_W-1:0]   last_ch;
   logic              any;
   logic [CH_W-1:0]   win;

   dma_req_detect #(.NUM_CH(NUM_CH)) u_detect (
      .clk      (clk),
      .rst_n    (rst_n),
      .dreq     (dreq),
      .sense    (sense_q),
      .mask     (mask_q),
      .clr      (clr),
      .req_qual (qual)
   );

   dma_prio_pick #(.NUM_CH(NUM_CH), .ROT_EN(ROT_EN)) u_pick (
      .req      (qual),
      .rot_mode (prio_q == PRIO_ROTATE),
      .last_ch  (last_ch),
      .any      (any),
      .win      (win)
   );

   logic            valid_q;
   logic [CH_W-1:0] ch_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid_q <= 1'b0;
         ch_q    <= '0;
      end else if (!hold) begin
         valid_q <= any;
         ch_q    <= win;
      end
   end

   assign req_valid = valid_q;
   assign req_ch    = ch_q;

   dma_grant_ctrl #(.NUM_CH(NUM_CH)) u_grant (
      .clk       (clk),
      .rst_n     (rst_n),
      .seq_grant (seq_grant),
      .req_valid (valid_q),
      .req_ch    (ch_q),
      .hold      (hold),
      .dack      (dack),
      .clr       (clr),
      .last_ch   (last_ch)
   );

   // R8
   hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      seq_grant |=> ($stable(req_ch) && $stable(req_valid)));

   // R9
   dack_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (|dack) |-> (req_valid && dack == (NUM_CH'(1) << req_ch)));
endmodule

// File: tb/tb_dma_req_arbiter.sv
module tb_dma_req_arbiter;
   localparam int N = 4;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [N-1:0] dreq = '0;
   logic         cfg_mask_we = 1'b0, cfg_sense_we = 1'b0, cfg_prio_we = 1'b0;
   logic [N-1:0] cfg_mask_d = '0, cfg_sense_d = '0;
   logic         cfg_prio_d = 1'b0;
   logic         seq_grant = 1'b0;
   logic         req_valid;
   logic [1:0]   req_ch;
   logic [N-1:0] dack;

   int n_run = 0;
   int n_fail = 0;

   always #4 clk = ~clk;

   dma_req_arbiter dut (
      .clk(clk), .rst_n(rst_n), .dreq(dreq),
      .cfg_mask_we(cfg_mask_we), .cfg_mask_d(cfg_mask_d),
      .cfg_sense_we(cfg_sense_we), .cfg_sense_d(cfg_sense_d),
      .cfg_prio_we(cfg_prio_we), .cfg_prio_d(cfg_prio_d),
      .seq_grant(seq_grant), .req_valid(req_valid), .req_ch(req_ch), .dack(dack)
   );

   task automatic step(input int n);
      repeat (n) @(posedge clk);
      @(negedge clk);
   endtask

   task automatic chk(input string rid, input int act, input int exp);
      n_run++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", rid, act, exp);
      end
   endtask

   function automatic int pick(input int pat, input int start);
      for (int k = 0; k < N; k++) begin
         int idx = (start + k) % N;
         if (pat[idx]) return idx;
      end
      return 0;
   endfunction

   task automatic wr_mask(input logic [N-1:0] v);
      cfg_mask_d = v; cfg_mask_we = 1'b1; step(1); cfg_mask_we = 1'b0; step(1);
   endtask
   task automatic wr_sense(input logic [N-1:0] v);
      cfg_sense_d = v; cfg_sense_we = 1'b1; step(1); cfg_sense_we = 1'b0; step(1);
   endtask
   task automatic wr_prio(input logic v);
      cfg_prio_d = v; cfg_prio_we = 1'b1; step(1); cfg_prio_we = 1'b0; step(1);
   endtask

   // serve the presented channel; drop its line if asked
   task automatic serve(input int ch, input bit drop);
      seq_grant = 1'b1;
      step(1);
      chk("R9 dack onehot", int'(dack), 1 << ch);
      step(1);
      chk("R9 dack held", int'(dack), 1 << ch);
      if (drop) dreq[ch] = 1'b0;
      seq_grant = 1'b0;
      step(1);
      chk("R10 dack released", int'(dack), 0);
      step(1);
   endtask

   initial begin
      #(8ns * 200000);
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      dreq = 4'hF;
      step(2);
      rst_n = 1'b1;
      step(2);
      // R1: all masked after reset
      chk("R1 req_valid", int'(req_valid), 0);
      chk("R1 dack", int'(dack), 0);

      // R2: write takes effect on the following edge
      cfg_mask_d = 4'h0; cfg_mask_we = 1'b1; step(1); cfg_mask_we = 1'b0;
      chk("R2 old mask at write edge", int'(req_valid), 0);
      step(1);
      chk("R2 new mask", int'(req_valid), 1);
      chk("R1 fixed after reset", int'(req_ch), 0);

      // R3: mask sweep with all lines high, fixed priority
      for (int m = 0; m < 16; m++) begin
         wr_mask(4'(m));
         chk("R3 valid", int'(req_valid), (m != 15) ? 1 : 0);
         if (m != 15) chk("R3 winner", int'(req_ch), pick(~m & 15, 0));
      end
      wr_mask(4'h0);

      // R4 and R6: level sense, fixed sweep
      for (int p = 0; p < 16; p++) begin
         dreq = 4'(p);
         step(1);
         chk("R4 valid", int'(req_valid), (p != 0) ? 1 : 0);
         if (p != 0) chk("R6 fixed winner", int'(req_ch), pick(p, 0));
      end
      dreq = '0; step(1);

      // R7: rotating after reset equals fixed; then sweep per last served
      wr_prio(1'b1);
      dreq = 4'hF; step(1);
      chk("R7 initial pointer", int'(req_ch), 0);
      dreq = '0; step(1);
      for (int l = 0; l < N; l++) begin
         dreq = 4'(1 << l); step(1);
         chk("R7 lone request", int'(req_ch), l);
         serve(l, 1'b1);
         for (int p = 1; p < 16; p++) begin
            dreq = 4'(p); step(1);
            chk("R7 rotating winner", int'(req_ch), pick(p, (l + 1) % N));
         end
         dreq = '0; step(1);
      end

      // R8: freeze while granted
      wr_prio(1'b0);
      dreq = 4'b1000; step(1);
      chk("R8 pre", int'(req_ch), 3);
      seq_grant = 1'b1;
      dreq = 4'b1001;
      step(3);
      chk("R8 ch frozen", int'(req_ch), 3);
      chk("R8 valid frozen", int'(req_valid), 1);
      chk("R9 dack ch3", int'(dack), 8);
      dreq[3] = 1'b0; seq_grant = 1'b0;
      step(1);
      chk("R10 dack off", int'(dack), 0);
      chk("R10 still held", int'(req_ch), 3);
      step(1);
      chk("R10 rearbitrated", int'(req_ch), 0);
      dreq = '0; step(1);

      // R11: grant without request
      chk("R11 idle", int'(req_valid), 0);
      seq_grant = 1'b1;
      step(1);
      dreq = 4'b0100;
      step(2);
      chk("R11 no dack", int'(dack), 0);
      chk("R11 no valid", int'(req_valid), 0);
      seq_grant = 1'b0;
      step(1);
      chk("R11 resumes", int'(req_valid), 1);
      chk("R11 resumes ch", int'(req_ch), 2);
      dreq = '0; step(1);

      // R5: edge sense, one-cycle pulse latched
      wr_sense(4'b0100);
      dreq[2] = 1'b1; step(1);
      dreq[2] = 1'b0;
      chk("R5 not yet", int'(req_valid), 0);
      step(1);
      chk("R5 latched", int'(req_valid), 1);
      chk("R5 latched ch", int'(req_ch), 2);
      step(4);
      chk("R5 stays pending", int'(req_valid), 1);
      serve(2, 1'b0);
      chk("R10 edge cleared", int'(req_valid), 0);
      // steady high line does not request again
      dreq[2] = 1'b1; step(2);
      chk("R5 edge seen", int'(req_valid), 1);
      serve(2, 1'b0);
      step(3);
      chk("R5 no retrigger", int'(req_valid), 0);
      dreq = '0; step(1);

      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule